// File: doc/BRIEF.md
# Fractional Baud Divisor Search Engine

This block picks the settings for a serial port's clock divider. A caller gives it the base clock frequency and the wanted line rate, both 32-bit integers, and pulses `start`. The engine then tries every legal pair of fractional multiplier `mul` and add value `divadd`. For each pair it finds the integer divisor `dl` and the rate error that the pair gives, and it keeps the pair with the smallest error. The line rate such a divider produces is `base * mul / (mul + divadd) / (16 * dl)`.

For each pair the engine forms a 64-bit fixed-point quotient with one shared shift-subtract divider. The integer half of the quotient is the candidate divisor and the fraction half is its error. The engine rounds the candidate to the nearest integer, rejects a divisor that is out of range, and keeps a running best. It stops at the first exact fit, or after the last pair. The control interface is plain: a one-cycle `start`, then `busy` for the whole search, then `done` with the three results and a `no_fit` flag. No data flows in a stream, so there is no back-pressure. The inputs are captured on the `start` cycle, and the outputs hold until the next accepted `start`.

Top module: `baud_div_search`

## Requirements
- R1: Pairs are tried in this order: `mul` rises from 1 to 15, and for each `mul` the value `divadd` rises from 0 to `mul`-1. A reported fit always has 1 <= `mul` <= 15 and `divadd` < `mul`.
- R2: For a pair, the quotient Q is floor((base * 2^28 * mul) / ((mul + divadd) * rate)), taken to 64 bits. Q[63:32] is the candidate divisor and Q[31:0] is its error.
- R3: If Q[31:0] is strictly greater than 2^31, the candidate divisor is raised by one and the error becomes 2^32 - Q[31:0]. A fraction of exactly 2^31 is not rounded. The error of a reported fit is therefore never above 2^31.
- R4: A candidate whose rounded divisor is below 1 or above 65536 is never chosen. A divisor of exactly 65536 is legal.
- R5: A candidate replaces the best only when its error is strictly smaller. On a tie the earlier pair is kept, so a reported `mul`/`divadd` ratio is always in lowest terms (`divadd` = 0 implies `mul` = 1).
- R6: The running best error starts at all ones. The search ends at the first candidate with zero error. When the first pair is exact, `done` rises within 200 cycles of `start`.
- R7: A `start` pulse while `busy` is high is ignored, and the running search finishes with the inputs it captured.
- R8: If no candidate is accepted (for example when the rate is 0 or the base is too small), the search ends with `done`=1, `no_fit`=1 and `dl`, `mul` and `divadd` all 0.
- R9: After reset, `busy`, `done`, `no_fit` and all results are 0. `busy` is high from the cycle after `start` until `done` rises. `done` and the results then hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a search; ignored while busy |
| base_freq | input | 32 | Base clock frequency in Hz, captured on start |
| baud_rate | input | 32 | Wanted line rate, captured on start |
| busy | output | 1 | Search in progress |
| done | output | 1 | Results valid; held until the next start |
| no_fit | output | 1 | No legal divisor exists for the request |
| dl | output | 17 | Integer divisor, 1 to 65536, or 0 on no fit |
| mul | output | 4 | Fractional multiplier, 1 to 15, or 0 on no fit |
| divadd | output | 4 | Fractional add value, below mul, or 0 on no fit |

## Verification
A wrong divider bit or a wrong rounding decision shows up only in the final result, after a full search of roughly 8000 cycles. The bench therefore compares every field against a model of the search built from the requirements, and it adds property checks that the reported error is at most half a divisor step and that the ratio is reduced. A fault in the pair walker or in the stop condition shows up earlier, as a wrong `done` latency: an exact first pair must finish in under 200 cycles, and a search must never run past its full length. A fault in the hold or capture logic shows up within a few cycles of `done` or of a stray `start`.

// File: rtl/baudsrch_pkg.sv
package baudsrch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } srch_state_e;
endpackage

// File: rtl/baudsrch_divider.sv
// Restoring shift-subtract divider: one quotient bit per cycle, MSB first.
module baudsrch_divider #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 40,
  localparam int CNT_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done,
  output logic             busy
);
  logic [NUM_W-1:0] num_sh_q, quo_q;
  logic [DEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;

  logic [DEN_W:0]   rem_sh, rem_sub;
  logic             fits;

  always_comb begin
    rem_sh  = {rem_q, num_sh_q[NUM_W-1]};
    fits    = rem_sh >= {1'b0, den};
    rem_sub = rem_sh - {1'b0, den};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_sh_q <= '0;
      quo_q    <= '0;
      rem_q    <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !run_q) begin
        num_sh_q <= num;
        quo_q    <= '0;
        rem_q    <= '0;
        cnt_q    <= CNT_W'(NUM_W);
        run_q    <= 1'b1;
      end else if (run_q) begin
        num_sh_q <= num_sh_q << 1;
        quo_q    <= {quo_q[NUM_W-2:0], fits};
        rem_q    <= fits ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
        cnt_q    <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo  = quo_q;
  assign done = done_q;
  assign busy = run_q;

  // R2: partial remainder stays below the divisor throughout the division
  a_r2_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && den != '0) |-> (rem_q < den));
  // R2: divisor operand is held while the division runs
  a_r2_den_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(den));
endmodule

// File: rtl/baudsrch_cand.sv
// Rounds one quotient to a candidate divisor and ranks its error.
module baudsrch_cand #(
  parameter int Q_W    = 64,
  parameter int FRAC_W = 32,
  parameter int DL_MAX = 65536,
  localparam int INT_W = Q_W - FRAC_W,
  localparam int DL_W  = $clog2(DL_MAX + 1)
) (
  input  logic [Q_W-1:0]    quo,
  output logic [DL_W-1:0]   cand_dl,
  output logic [FRAC_W-1:0] cand_err,
  output logic              cand_ok
);
  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

  logic [FRAC_W-1:0] frac;
  logic [INT_W:0]    rounded;
  logic              up;

  always_comb begin
    frac     = quo[FRAC_W-1:0];
    up       = frac > HALF;
    rounded  = {1'b0, quo[Q_W-1:FRAC_W]} + (INT_W+1)'(up);
    cand_err = up ? (~frac + 1'b1) : frac;
    cand_ok  = (rounded >= (INT_W+1)'(1)) && (rounded <= (INT_W+1)'(DL_MAX));
    cand_dl  = rounded[DL_W-1:0];
  end

  // R3: an accepted candidate never carries more than half a step of error
  always_comb begin
    if (cand_ok) a_r3_err_half_step: assert (cand_err <= HALF);
  end
endmodule

// File: rtl/baudsrch_pair_walk.sv
// Steps the (mul, divadd) pair through the legal triangle in search order.
module baudsrch_pair_walk #(
  parameter int MUL_MAX = 15,
  localparam int MUL_W = $clog2(MUL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic [MUL_W-1:0] cur_mul,
  output logic [MUL_W-1:0] cur_div,
  output logic             last
);
  logic [MUL_W-1:0] mul_q, div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mul_q <= MUL_W'(1);
      div_q <= '0;
    end else if (restart) begin
      mul_q <= MUL_W'(1);
      div_q <= '0;
    end else if (advance && !last) begin
      if (div_q == mul_q - 1'b1) begin
        mul_q <= mul_q + 1'b1;
        div_q <= '0;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign cur_mul = mul_q;
  assign cur_div = div_q;
  assign last    = (mul_q == MUL_W'(MUL_MAX)) && (div_q == MUL_W'(MUL_MAX - 1));

  // R1: the walker only ever presents legal pairs
  a_r1_pair_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_q >= MUL_W'(1)) && (mul_q <= MUL_W'(MUL_MAX)) && (div_q < mul_q));
  // R1: on advance, either divadd rises by one or mul rises and divadd restarts
  a_r1_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !last && !restart) |=>
      ((mul_q == $past(mul_q) && div_q == $past(div_q) + 1'b1) ||
       (mul_q == $past(mul_q) + 1'b1 && div_q == '0)));
endmodule

// File: rtl/baud_div_search.sv
module baud_div_search
  import baudsrch_pkg::*;
#(
  parameter int FREQ_W   = 32,
  parameter int FRAC_W   = 32,
  parameter int OVS_LOG2 = 4,
  parameter int MUL_MAX  = 15,
  parameter int DL_MAX   = 65536,
  localparam int DL_W    = $clog2(DL_MAX + 1),
  localparam int MUL_W   = $clog2(MUL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] base_freq,
  input  logic [FREQ_W-1:0] baud_rate,
  output logic              busy,
  output logic              done,
  output logic              no_fit,
  output logic [DL_W-1:0]   dl,
  output logic [MUL_W-1:0]  mul,
  output logic [MUL_W-1:0]  divadd
);
  localparam int Q_W   = FREQ_W + FRAC_W;
  localparam int SHIFT = FRAC_W - OVS_LOG2;
  localparam int SUM_W = $clog2(2 * MUL_MAX);
  localparam int DEN_W = FREQ_W + 8;

  srch_state_e       state_q;
  logic [FREQ_W-1:0] base_q, baud_q;
  logic [FRAC_W-1:0] best_err;
  logic [DL_W-1:0]   best_dl;
  logic [MUL_W-1:0]  best_mul, best_div;
  logic              done_q, nofit_q;

  logic [MUL_W-1:0]  cur_mul, cur_div;
  logic              last_pair;
  logic [SUM_W-1:0]  pair_sum;
  logic [Q_W-1:0]    div_num, div_quo;
  logic [DEN_W-1:0]  div_den;
  logic              div_go, div_done, div_busy;
  logic [DL_W-1:0]   cand_dl;
  logic [FRAC_W-1:0] cand_err;
  logic              cand_ok, take, accept_start, finish;

  assign accept_start = (state_q == ST_IDLE) && start;
  assign div_go       = (state_q == ST_ISSUE);
  assign pair_sum     = SUM_W'(cur_mul) + SUM_W'(cur_div);
  assign div_num      = (Q_W'(base_q) << SHIFT) * Q_W'(cur_mul);
  assign div_den      = DEN_W'(pair_sum) * DEN_W'(baud_q);
  assign take         = cand_ok && (cand_err < best_err);
  assign finish       = (state_q == ST_WAIT) && div_done &&
                        ((take && cand_err == '0) || last_pair);

  baudsrch_pair_walk #(.MUL_MAX(MUL_MAX)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept_start),
    .advance ((state_q == ST_WAIT) && div_done),
    .cur_mul (cur_mul),
    .cur_div (cur_div),
    .last    (last_pair)
  );

  baudsrch_divider #(.NUM_W(Q_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .quo   (div_quo),
    .done  (div_done),
    .busy  (div_busy)
  );

  baudsrch_cand #(.Q_W(Q_W), .FRAC_W(FRAC_W), .DL_MAX(DL_MAX)) u_cand (
    .quo      (div_quo),
    .cand_dl  (cand_dl),
    .cand_err (cand_err),
    .cand_ok  (cand_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      baud_q   <= '0;
      best_err <= '1;
      best_dl  <= '0;
      best_mul <= '0;
      best_div <= '0;
      done_q   <= 1'b0;
      nofit_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            base_q   <= base_freq;
            baud_q   <= baud_rate;
            best_err <= '1;
            best_dl  <= '0;
            best_mul <= '0;
            best_div <= '0;
            done_q   <= 1'b0;
            nofit_q  <= 1'b0;
            state_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (div_done) begin
            if (take) begin
              best_err <= cand_err;
              best_dl  <= cand_dl;
              best_mul <= cur_mul;
              best_div <= cur_div;
            end
            if (finish) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              nofit_q <= !take && (best_dl == '0);
            end else begin
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign no_fit = nofit_q;
  assign dl     = best_dl;
  assign mul    = best_mul;
  assign divadd = best_div;

  // R7: a start while searching leaves the captured operands untouched
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start) |=> ($stable(base_q) && $stable(baud_q)));
  // R5: during a search the best error never grows
  a_r5_best_err_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (best_err <= $past(best_err)));
  // R4: a reported fit has a divisor inside the legal range
  a_r4_dl_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !nofit_q) |-> (best_dl >= DL_W'(1) && best_dl <= DL_W'(DL_MAX)));
  // R8: a failed search reports all-zero results
  a_r8_nofit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && nofit_q) |-> (best_dl == '0 && best_mul == '0 && best_div == '0));
  // R9: results and done hold until the next start
  a_r9_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> (done_q && $stable(best_dl) && $stable(best_mul) &&
                            $stable(best_div) && $stable(nofit_q)));
  // R9: done and busy are never high together
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && state_q != ST_IDLE));
  // R1: the divider is never asked to start while it is still running
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !div_busy);
endmodule

// File: tb/tb_baud_div_search.sv
module tb_baud_div_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0;
  logic [31:0] baud = '0;
  logic        busy, done, no_fit;
  logic [16:0] dl;
  logic [3:0]  mul, divadd;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  baud_div_search dut (
    .clk (clk), .rst_n (rst_n), .start (start),
    .base_freq (base), .baud_rate (baud),
    .busy (busy), .done (done), .no_fit (no_fit),
    .dl (dl), .mul (mul), .divadd (divadd)
  );

  localparam int NVEC = 11;
  localparam logic [63:0] VEC [NVEC] = '{
    {32'd12000000,  32'd115200},
    {32'd204000000, 32'd115200},
    {32'd48,        32'd2},
    {32'd16,        32'd1},
    {32'd1048576,   32'd1},
    {32'd1048592,   32'd1},
    {32'd1,         32'd1000000},
    {32'hFFFFFFFF,  32'd1},
    {32'd100000000, 32'd9600},
    {32'd180000000, 32'd3000000},
    {32'd17,        32'd0}
  };

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Search model written from R1..R6, R8
  task automatic model(input logic [31:0] b, input logic [31:0] r,
                       output longint e_dl, output longint e_mul,
                       output longint e_div, output longint e_nofit);
    longint unsigned best_err = 64'hFFFF_FFFF;
    e_dl = 0; e_mul = 0; e_div = 0;
    for (int m = 1; m <= 15; m++) begin
      for (int d = 0; d < m; d++) begin
        longint unsigned num, den, q, fr, cdl, er;
        num = (longint'(b) << 28) * longint'(m);
        den = longint'(m + d) * longint'(r);
        if (den == 0) continue;
        q   = num / den;
        fr  = q & 64'hFFFF_FFFF;
        cdl = q >> 32;
        er  = fr;
        if (fr > 64'h8000_0000) begin
          cdl = cdl + 1;
          er  = 64'h1_0000_0000 - fr;
        end
        if (cdl < 1 || cdl > 65536) continue;
        if (er < best_err) begin
          best_err = er; e_dl = cdl; e_mul = m; e_div = d;
          if (er == 0) break;
        end
      end
      if (best_err == 0) break;
    end
    e_nofit = (e_dl == 0) ? 1 : 0;
  endtask

  function automatic int gcd(input int a, input int b);
    int x = a, y = b;
    while (y != 0) begin int t = x % y; x = y; y = t; end
    return x;
  endfunction

  task automatic run_search(input logic [31:0] b, input logic [31:0] r, output int cyc);
    @(negedge clk);
    base = b; baud = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic compare_model(input logic [31:0] b, input logic [31:0] r, input string req);
    longint e_dl, e_mul, e_div, e_nf;
    model(b, r, e_dl, e_mul, e_div, e_nf);
    check({req, " dl"},     dl,     e_dl);
    check({req, " mul"},    mul,    e_mul);
    check({req, " divadd"}, divadd, e_div);
    check({req, " no_fit"}, no_fit, e_nf);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL R9 watchdog actual=hang expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 reset busy", busy, 0);
    check("R9 reset done", done, 0);
    check("R9 reset no_fit", no_fit, 0);
    check("R9 reset results", {dl, mul, divadd}, 0);

    // Table walk: every field against the model, plus result properties
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] vb, vr;
      vb = VEC[i][63:32];
      vr = VEC[i][31:0];
      run_search(vb, vr, cyc);
      check("R9 done rises", done, 1);
      compare_model(vb, vr, "R2 R3 R4 R5 vector");
      if (!no_fit) begin
        longint unsigned num, den, q, fr, er;
        check("R1 mul legal", (mul >= 1 && mul <= 15) ? 1 : 0, 1);
        check("R1 divadd below mul", (divadd < mul) ? 1 : 0, 1);
        check("R5 ratio reduced",
              (divadd == 0) ? ((mul == 1) ? 1 : 0) : gcd(int'(mul), int'(divadd)), 1);
        num = (longint'(vb) << 28) * longint'(mul);
        den = longint'(mul + divadd) * longint'(vr);
        q   = num / den;
        fr  = q & 64'hFFFF_FFFF;
        er  = (fr > 64'h8000_0000) ? 64'h1_0000_0000 - fr : fr;
        check("R3 error at most half step", (er <= 64'h8000_0000) ? 1 : 0, 1);
        check("R4 dl in range", (dl >= 1 && dl <= 65536) ? 1 : 0, 1);
      end
    end

    // R6: exact first pair ends early; R5: later equal pairs (k,0) not taken
    run_search(32'd16, 32'd1, cyc);
    check("R6 early stop latency", (cyc < 200) ? 1 : 0, 1);
    check("R6 exact dl", dl, 1);
    check("R5 tie keeps mul=1", mul, 1);
    check("R5 tie keeps divadd=0", divadd, 0);

    // R3: fraction of exactly 2^31 not rounded, exact pair (2,1) wins later
    run_search(32'd48, 32'd2, cyc);
    check("R3 half fraction dl", dl, 1);
    check("R3 half fraction mul", mul, 2);
    check("R3 half fraction divadd", divadd, 1);

    // R4: top of divisor range accepted
    run_search(32'd1048576, 32'd1, cyc);
    check("R4 dl=65536 accepted", dl, 65536);
    check("R4 dl=65536 no_fit", no_fit, 0);

    // R8: zero rate gives no fit
    run_search(32'd17, 32'd0, cyc);
    check("R8 no_fit flag", no_fit, 1);
    check("R8 zero results", {dl, mul, divadd}, 0);
    check("R8 done", done, 1);

    // R7: second start during a search is ignored
    @(negedge clk);
    base = 32'd12000000; baud = 32'd115200; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 busy during search", busy, 1);
    base = 32'd1; baud = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    compare_model(32'd12000000, 32'd115200, "R7 start ignored");

    // R9: outputs hold after done
    begin
      logic [24:0] snap;
      snap = {dl, mul, divadd};
      base = 32'd48; baud = 32'd2;
      repeat (25) @(negedge clk);
      check("R9 results held", {dl, mul, divadd}, snap);
      check("R9 done held", done, 1);
      check("R9 busy low after done", busy, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule